// File: doc/BRIEF.md
# Accuracy-Selectable Floating-Point Divider

This block divides one single-precision value by another and lets every operation choose how many leading bits of the result mantissa are worth computing. The quotient mantissa comes out one bit per clock, most significant bit first, from a non-restoring recurrence. The loop stops as soon as the requested number of bits exists. A coarse request therefore returns after only a few cycles, and a full request gives the same mantissa as an ordinary truncating single-precision divide.

Sign and exponent do not depend on the accuracy request and are always exact. Only the mantissa is shortened: bits below the requested count come out as zero. Zero, infinite and NaN operands, divide-by-zero, and exponent overflow or underflow are settled in a single cycle without running the recurrence. Subnormal operands are flushed to zero. A caller raises a start strobe with the operands and the accuracy code, waits while busy is high, and takes the result on the one-cycle done pulse. The result stays on the outputs until the next completion.

Top module: `acc_fdiv`

## Requirements
- R1: While reset is active and after its release, before any operation, busy_o, done_o, quot_o, dz_o and iters_o are all zero. A reset in the middle of an operation returns them to zero.
- R2: With 24 bits requested, quot_o carries the truncated quotient mantissa, bit-exact. Examples: 6.0/2.0 gives 0x40400000, 1.0/3.0 gives 0x3EAAAAAA, and 0x3FFFFFFF/0x3F800001 gives 0x3FFFFFFD.
- R3: acc_i (5 bits) gives the number of mantissa bits to compute, counting the hidden leading one. Values 1 to 24 are used as given. Values 0 and 25 to 31 mean 24.
- R4: With n bits requested, the 24-n lowest fraction bits of quot_o are zero and the bits above them match the full-accuracy quotient. Examples for 1.0/3.0: n=8 gives 0x3EAA0000, n=3 gives 0x3EA00000, n=1 gives 0x3E800000.
- R5: For a computed result, done_o rises n+1 rising edges after the edge that samples start_i, and iters_o equals n.
- R6: The sign is the XOR of the operand signs. The biased exponent is ea - eb + 127, lowered by one when the dividend mantissa is smaller than the divisor mantissa. This holds for every accuracy.
- R7: A finite nonzero value divided by zero gives an infinity with the XOR sign (exponent field all ones, fraction zero) and sets dz_o. Zero divided by a finite nonzero value gives a zero with the XOR sign and dz_o low.
- R8: A NaN operand, 0/0 and infinity/infinity give 0x7FC00000. Infinity divided by a finite value gives a signed infinity. A finite value divided by infinity gives a signed zero. dz_o stays low in all of these cases.
- R9: An operand with exponent field zero is treated as zero, whatever its fraction.
- R10: A biased result exponent of 255 or more gives a signed infinity, and one of 0 or less gives a signed zero. An exponent of 254 is kept. Every special-case result (R7 to R10) takes one edge after the start edge, with iters_o equal to 0.
- R11: done_o is a one-cycle pulse. busy_o is high from the edge that accepts start_i until the edge that raises done_o. A start_i while busy_o is high is ignored.
- R12: quot_o, dz_o and iters_o change only on the edge that raises done_o, and hold their values between completions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts an operation when the block is idle |
| dividend_i | input | 32 | Dividend, single-precision |
| divisor_i | input | 32 | Divisor, single-precision |
| acc_i | input | 5 | Number of mantissa bits to compute (0 or above 24 means 24) |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| quot_o | output | 32 | Quotient, held until the next completion |
| dz_o | output | 1 | Divide-by-zero flag for the last result |
| iters_o | output | 5 | Recurrence iterations used by the last result |

## Verification
The bench builds the divider with its default parameters: an 8-bit exponent, a 23-bit fraction and a 5-bit accuracy field. This gives real single-precision encodings for the expected words, and it lets the unused accuracy codes 25 to 31, which a 5-bit field can carry, be exercised alongside code 0. At this width the exponent boundaries 254 and 255 can be reached with ordinary operands. The longest recurrence is 24 steps, so full-accuracy, truncation-boundary and one-bit cases can all be timed cycle by cycle.

// File: rtl/acc_fdiv_pkg.sv
package acc_fdiv_pkg;

   // Operand classes after subnormal flushing
   typedef enum logic [1:0] {
      OPC_ZERO,
      OPC_FIN,
      OPC_INF,
      OPC_NAN
   } opc_e;

   // Control states of the divider
   typedef enum logic [1:0] {
      ST_IDLE,
      ST_ITER,
      ST_WRAP
   } st_e;

endpackage

// File: rtl/acc_fdiv_unpack.sv
module acc_fdiv_unpack
   import acc_fdiv_pkg::*;
#(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23
) (
   input  logic [EXP_W+FRAC_W:0] word_i,
   output logic                  sgn_o,
   output logic [EXP_W-1:0]      exp_o,
   output logic [FRAC_W:0]       mant_o,
   output opc_e                  cls_o
);

   localparam int W = 1 + EXP_W + FRAC_W;

   logic [EXP_W-1:0]  fld_exp;
   logic [FRAC_W-1:0] fld_frac;

   assign fld_exp  = word_i[W-2 -: EXP_W];
   assign fld_frac = word_i[FRAC_W-1:0];
   assign sgn_o    = word_i[W-1];
   assign exp_o    = fld_exp;
   assign mant_o   = {1'b1, fld_frac};

   // Zero exponent field flushes the operand to zero
   always_comb begin
      if (fld_exp == '0) begin
         cls_o = OPC_ZERO;
      end else if (fld_exp == '1) begin
         cls_o = (fld_frac == '0) ? OPC_INF : OPC_NAN;
      end else begin
         cls_o = OPC_FIN;
      end
   end

endmodule

// File: rtl/acc_fdiv_setup.sv
module acc_fdiv_setup
   import acc_fdiv_pkg::*;
#(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23
) (
   input  logic                  sa_i,
   input  logic                  sb_i,
   input  logic [EXP_W-1:0]      ea_i,
   input  logic [EXP_W-1:0]      eb_i,
   input  logic [FRAC_W:0]       ma_i,
   input  logic [FRAC_W:0]       mb_i,
   input  opc_e                  ca_i,
   input  opc_e                  cb_i,
   output logic                  special_o,
   output logic [EXP_W+FRAC_W:0] spec_word_o,
   output logic                  dz_o,
   output logic                  sgn_o,
   output logic [EXP_W-1:0]      exp_o,
   output logic [FRAC_W+1:0]     num_o,
   output logic [FRAC_W:0]       den_o
);

   localparam int W    = 1 + EXP_W + FRAC_W;
   localparam int MW   = FRAC_W + 1;
   localparam int BIAS = (1 << (EXP_W - 1)) - 1;
   localparam int EMAX = (1 << EXP_W) - 1;
   localparam int XW   = EXP_W + 2;

   logic                 m_lt;
   logic signed [XW-1:0] e_full;
   logic                 e_ovf;
   logic                 e_unf;
   logic [W-1:0]         w_qnan;
   logic [W-1:0]         w_inf;
   logic [W-1:0]         w_zero;

   assign m_lt   = (ma_i < mb_i);
   assign e_full = XW'(ea_i) - XW'(eb_i) + XW'(BIAS) - XW'(m_lt);
   assign e_ovf  = (e_full >= $signed(XW'(EMAX)));
   assign e_unf  = (e_full < $signed(XW'(1)));

   assign sgn_o  = sa_i ^ sb_i;
   assign exp_o  = e_full[EXP_W-1:0];
   // Normalise the dividend so the quotient lies in [1, 2)
   assign num_o  = m_lt ? {ma_i, 1'b0} : {1'b0, ma_i};
   assign den_o  = mb_i;

   assign w_qnan = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
   assign w_inf  = {sgn_o, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
   assign w_zero = {sgn_o, {(W-1){1'b0}}};

   always_comb begin
      special_o   = 1'b1;
      spec_word_o = w_zero;
      dz_o        = 1'b0;
      if ((ca_i == OPC_NAN) || (cb_i == OPC_NAN) ||
          ((ca_i == OPC_ZERO) && (cb_i == OPC_ZERO)) ||
          ((ca_i == OPC_INF) && (cb_i == OPC_INF))) begin
         spec_word_o = w_qnan;
      end else if (ca_i == OPC_INF) begin
         spec_word_o = w_inf;
      end else if (cb_i == OPC_INF) begin
         spec_word_o = w_zero;
      end else if (cb_i == OPC_ZERO) begin
         spec_word_o = w_inf;
         dz_o        = 1'b1;
      end else if (ca_i == OPC_ZERO) begin
         spec_word_o = w_zero;
      end else if (e_ovf) begin
         spec_word_o = w_inf;
      end else if (e_unf) begin
         spec_word_o = w_zero;
      end else begin
         special_o   = 1'b0;
      end
   end

   if (MW < 2) begin : g_bad_mw
      $error("acc_fdiv_setup: mantissa too narrow");
   end

endmodule

// File: rtl/acc_fdiv_nr_core.sv
module acc_fdiv_nr_core #(
   parameter int MW = 24
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic          step_i,
   input  logic [MW:0]   num_i,
   input  logic [MW-1:0] den_i,
   output logic [MW-1:0] quo_o
);

   localparam int RW = MW + 3;

   logic signed [RW-1:0] rem_q;
   logic [MW-1:0]        den_q;
   logic [MW-1:0]        quo_q;
   logic signed [RW-1:0] d_ext;
   logic signed [RW-1:0] rem_dbl;
   logic signed [RW-1:0] rem_nxt;
   logic                 bit_now;

   assign d_ext   = $signed(RW'(den_q));
   assign rem_dbl = rem_q <<< 1;
   // Non-restoring update: add back when negative, subtract otherwise
   assign rem_nxt = rem_q[RW-1] ? (rem_dbl + d_ext) : (rem_dbl - d_ext);
   assign bit_now = ~rem_q[RW-1];
   assign quo_o   = quo_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q <= '0;
         den_q <= '0;
         quo_q <= '0;
      end else if (load_i) begin
         rem_q <= $signed(RW'(num_i)) - $signed(RW'(den_i));
         den_q <= den_i;
         quo_q <= '0;
      end else if (step_i) begin
         quo_q <= {quo_q[MW-2:0], bit_now};
         rem_q <= rem_nxt;
      end
   end

endmodule

// File: rtl/acc_fdiv_pack.sv
module acc_fdiv_pack #(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23,
   parameter int CNT_W  = 5
) (
   input  logic                  spec_i,
   input  logic [EXP_W+FRAC_W:0] spec_word_i,
   input  logic                  sgn_i,
   input  logic [EXP_W-1:0]      exp_i,
   input  logic [FRAC_W:0]       quo_i,
   input  logic [CNT_W-1:0]      nbits_i,
   output logic [EXP_W+FRAC_W:0] word_o
);

   localparam int MW = FRAC_W + 1;

   logic [CNT_W-1:0] sh;

   // Align the leading one to the hidden position; vacated bits are zero
   assign sh     = CNT_W'(MW) - nbits_i;
   assign word_o = spec_i ? spec_word_i
                          : {sgn_i, exp_i, FRAC_W'(quo_i << sh)};

endmodule

// File: rtl/acc_fdiv.sv
module acc_fdiv
   import acc_fdiv_pkg::*;
#(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23,
   parameter int ACC_W  = 5,
   localparam int CNT_W = $clog2(FRAC_W + 2)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start_i,
   input  logic [EXP_W+FRAC_W:0] dividend_i,
   input  logic [EXP_W+FRAC_W:0] divisor_i,
   input  logic [ACC_W-1:0]      acc_i,
   output logic                  busy_o,
   output logic                  done_o,
   output logic [EXP_W+FRAC_W:0] quot_o,
   output logic                  dz_o,
   output logic [CNT_W-1:0]      iters_o
);

   localparam int W  = 1 + EXP_W + FRAC_W;
   localparam int MW = FRAC_W + 1;
   localparam int NOP = 2;

   if (EXP_W < 3) begin : g_bad_exp
      $error("acc_fdiv: EXP_W must be at least 3");
   end
   if ((1 << ACC_W) <= MW) begin : g_bad_acc
      $error("acc_fdiv: ACC_W cannot express full accuracy");
   end

   // ---------------- operand unpacking ----------------
   logic [W-1:0]     op_word [NOP];
   logic [NOP-1:0]   op_sgn;
   logic [EXP_W-1:0] op_exp  [NOP];
   logic [MW-1:0]    op_mant [NOP];
   opc_e             op_cls  [NOP];

   assign op_word[0] = dividend_i;
   assign op_word[1] = divisor_i;

   for (genvar gi = 0; gi < NOP; gi++) begin : g_unp
      acc_fdiv_unpack #(
         .EXP_W  (EXP_W),
         .FRAC_W (FRAC_W)
      ) u_unp (
         .word_i (op_word[gi]),
         .sgn_o  (op_sgn[gi]),
         .exp_o  (op_exp[gi]),
         .mant_o (op_mant[gi]),
         .cls_o  (op_cls[gi])
      );
   end

   // ---------------- setup: sign, exponent, specials ----------------
   logic             su_special;
   logic [W-1:0]     su_word;
   logic             su_dz;
   logic             su_sgn;
   logic [EXP_W-1:0] su_exp;
   logic [MW:0]      su_num;
   logic [MW-1:0]    su_den;

   acc_fdiv_setup #(
      .EXP_W  (EXP_W),
      .FRAC_W (FRAC_W)
   ) u_setup (
      .sa_i        (op_sgn[0]),
      .sb_i        (op_sgn[1]),
      .ea_i        (op_exp[0]),
      .eb_i        (op_exp[1]),
      .ma_i        (op_mant[0]),
      .mb_i        (op_mant[1]),
      .ca_i        (op_cls[0]),
      .cb_i        (op_cls[1]),
      .special_o   (su_special),
      .spec_word_o (su_word),
      .dz_o        (su_dz),
      .sgn_o       (su_sgn),
      .exp_o       (su_exp),
      .num_o       (su_num),
      .den_o       (su_den)
   );

   // ---------------- accuracy decode ----------------
   logic [CNT_W-1:0] n_sel;
   assign n_sel = ((acc_i == '0) || (int'(acc_i) > MW)) ? CNT_W'(MW)
                                                         : CNT_W'(acc_i);

   // ---------------- control ----------------
   st_e              st_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] n_q;
   logic             sgn_q;
   logic [EXP_W-1:0] exp_q;
   logic             spec_q;
   logic [W-1:0]     specw_q;
   logic             dzp_q;
   logic             accept;
   logic [MW-1:0]    core_quo;
   logic [W-1:0]     packed_word;

   assign accept = (st_q == ST_IDLE) && start_i;
   assign busy_o = (st_q != ST_IDLE);

   acc_fdiv_nr_core #(
      .MW (MW)
   ) u_core (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (accept),
      .step_i (st_q == ST_ITER),
      .num_i  (su_num),
      .den_i  (su_den),
      .quo_o  (core_quo)
   );

   acc_fdiv_pack #(
      .EXP_W  (EXP_W),
      .FRAC_W (FRAC_W),
      .CNT_W  (CNT_W)
   ) u_pack (
      .spec_i      (spec_q),
      .spec_word_i (specw_q),
      .sgn_i       (sgn_q),
      .exp_i       (exp_q),
      .quo_i       (core_quo),
      .nbits_i     (n_q),
      .word_o      (packed_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         cnt_q   <= '0;
         n_q     <= '0;
         sgn_q   <= 1'b0;
         exp_q   <= '0;
         spec_q  <= 1'b0;
         specw_q <= '0;
         dzp_q   <= 1'b0;
         done_o  <= 1'b0;
         quot_o  <= '0;
         dz_o    <= 1'b0;
         iters_o <= '0;
      end else begin
         done_o <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (start_i) begin
                  n_q     <= n_sel;
                  cnt_q   <= '0;
                  sgn_q   <= su_sgn;
                  exp_q   <= su_exp;
                  spec_q  <= su_special;
                  specw_q <= su_word;
                  dzp_q   <= su_dz;
                  st_q    <= su_special ? ST_WRAP : ST_ITER;
               end
            end
            ST_ITER: begin
               cnt_q <= cnt_q + CNT_W'(1);
               if (cnt_q == (n_q - CNT_W'(1))) begin
                  st_q <= ST_WRAP;
               end
            end
            ST_WRAP: begin
               st_q    <= ST_IDLE;
               done_o  <= 1'b1;
               quot_o  <= packed_word;
               dz_o    <= dzp_q;
               iters_o <= spec_q ? '0 : n_q;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/acc_fdiv_chk.sv
module acc_fdiv_chk #(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23,
   localparam int CNT_W = $clog2(FRAC_W + 2)
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  start_i,
   input logic                  busy_o,
   input logic                  done_o,
   input logic [EXP_W+FRAC_W:0] quot_o,
   input logic                  dz_o,
   input logic [CNT_W-1:0]      iters_o
);

   localparam int MW = FRAC_W + 1;

   p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

   p_busy_end_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> done_o);

   p_start_taken_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> busy_o);

   p_iters_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (iters_o <= CNT_W'(MW)));

   p_dz_inf_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && dz_o) |-> (quot_o[EXP_W+FRAC_W-1:0] ==
                            {{EXP_W{1'b1}}, {FRAC_W{1'b0}}}));

   p_hold_res_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(quot_o) |-> done_o);

   p_hold_meta_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(iters_o) || !$stable(dz_o)) |-> done_o);

endmodule

bind acc_fdiv acc_fdiv_chk #(
   .EXP_W  (EXP_W),
   .FRAC_W (FRAC_W)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start_i (start_i),
   .busy_o  (busy_o),
   .done_o  (done_o),
   .quot_o  (quot_o),
   .dz_o    (dz_o),
   .iters_o (iters_o)
);

// File: tb/acc_fdiv_tb.sv
module acc_fdiv_tb_top;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [31:0] dividend_i = '0;
   logic [31:0] divisor_i = '0;
   logic [4:0]  acc_i = '0;
   logic        busy_o;
   logic        done_o;
   logic [31:0] quot_o;
   logic        dz_o;
   logic [4:0]  iters_o;

   int n_chk = 0;
   int n_err = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   acc_fdiv dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .dividend_i (dividend_i),
      .divisor_i  (divisor_i),
      .acc_i      (acc_i),
      .busy_o     (busy_o),
      .done_o     (done_o),
      .quot_o     (quot_o),
      .dz_o       (dz_o),
      .iters_o    (iters_o)
   );

   typedef struct packed {
      logic [31:0] a;
      logic [31:0] b;
      logic [4:0]  acc;
      logic [31:0] res;
      logic        dz;
      logic [4:0]  cyc;
      logic [3:0]  rq;
   } vec_t;

   localparam int NV = 26;
   localparam vec_t VT [NV] = '{
      '{32'h40C00000, 32'h40000000, 5'd24, 32'h40400000, 1'b0, 5'd24, 4'd2},  // R2 6/2
      '{32'h3F800000, 32'h40400000, 5'd24, 32'h3EAAAAAA, 1'b0, 5'd24, 4'd2},  // R2 1/3 truncated
      '{32'h3F800000, 32'h40400000, 5'd8,  32'h3EAA0000, 1'b0, 5'd8,  4'd4},  // R4
      '{32'h3F800000, 32'h40400000, 5'd1,  32'h3E800000, 1'b0, 5'd1,  4'd4},  // R4 one bit
      '{32'h3F800000, 32'h40400000, 5'd3,  32'h3EA00000, 1'b0, 5'd3,  4'd4},  // R4
      '{32'hC0E00000, 32'h40000000, 5'd0,  32'hC0600000, 1'b0, 5'd24, 4'd3},  // R3 code 0
      '{32'h3F800000, 32'h40400000, 5'd31, 32'h3EAAAAAA, 1'b0, 5'd24, 4'd3},  // R3 code 31
      '{32'h3F800000, 32'h40400000, 5'd25, 32'h3EAAAAAA, 1'b0, 5'd24, 4'd3},  // R3 code 25
      '{32'h41200000, 32'hC0800000, 5'd3,  32'hC0200000, 1'b0, 5'd3,  4'd6},  // R6 sign
      '{32'h3FFFFFFF, 32'h3F800001, 5'd24, 32'h3FFFFFFD, 1'b0, 5'd24, 4'd2},  // R2 max mantissa
      '{32'h3F800000, 32'h3FFFFFFF, 5'd24, 32'h3F000000, 1'b0, 5'd24, 4'd6},  // R6 exp minus one
      '{32'h3F800000, 32'h3FFFFFFF, 5'd5,  32'h3F000000, 1'b0, 5'd5,  4'd6},  // R6 low accuracy
      '{32'h40A00000, 32'h00000000, 5'd24, 32'h7F800000, 1'b1, 5'd0,  4'd7},  // R7 x/0
      '{32'hC0A00000, 32'h00000000, 5'd10, 32'hFF800000, 1'b1, 5'd0,  4'd7},  // R7 -x/0
      '{32'h00000000, 32'h40400000, 5'd24, 32'h00000000, 1'b0, 5'd0,  4'd7},  // R7 0/x
      '{32'h80000000, 32'h40400000, 5'd24, 32'h80000000, 1'b0, 5'd0,  4'd7},  // R7 -0/x
      '{32'h00000000, 32'h00000000, 5'd24, 32'h7FC00000, 1'b0, 5'd0,  4'd8},  // R8 0/0
      '{32'h7FC00001, 32'h3F800000, 5'd24, 32'h7FC00000, 1'b0, 5'd0,  4'd8},  // R8 NaN
      '{32'h7F800000, 32'hC0000000, 5'd24, 32'hFF800000, 1'b0, 5'd0,  4'd8},  // R8 inf/x
      '{32'h40000000, 32'h7F800000, 5'd24, 32'h00000000, 1'b0, 5'd0,  4'd8},  // R8 x/inf
      '{32'h7F800000, 32'h7F800000, 5'd24, 32'h7FC00000, 1'b0, 5'd0,  4'd8},  // R8 inf/inf
      '{32'h00000001, 32'h3F800000, 5'd24, 32'h00000000, 1'b0, 5'd0,  4'd9},  // R9 subnormal/x
      '{32'h3F800000, 32'h00000001, 5'd24, 32'h7F800000, 1'b1, 5'd0,  4'd9},  // R9 x/subnormal
      '{32'h7F000000, 32'h3E800000, 5'd24, 32'h7F800000, 1'b0, 5'd0,  4'd10}, // R10 overflow
      '{32'h00800000, 32'h40000000, 5'd24, 32'h00000000, 1'b0, 5'd0,  4'd10}, // R10 underflow
      '{32'h7F000000, 32'h3F800000, 5'd12, 32'h7F000000, 1'b0, 5'd12, 4'd10}  // R10 exp 254 kept
   };

   function automatic string rname(logic [3:0] k);
      case (k)
         4'd2:    return "R2";
         4'd3:    return "R3";
         4'd4:    return "R4";
         4'd6:    return "R6";
         4'd7:    return "R7";
         4'd8:    return "R8";
         4'd9:    return "R9";
         default: return "R10";
      endcase
   endfunction

   task automatic check(input bit ok, input string tag,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
      end
   endtask

   logic [31:0] r_res;
   logic        r_dz;
   logic [4:0]  r_it;
   int          r_lat;

   // Drive one operation; r_lat counts edges after the start edge up to done
   task automatic run_op(input logic [31:0] a, input logic [31:0] b,
                         input logic [4:0] acc);
      @(negedge clk);
      dividend_i = a;
      divisor_i  = b;
      acc_i      = acc;
      start_i    = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      r_lat   = 0;
      while (!done_o && r_lat < 100) begin
         @(negedge clk);
         r_lat++;
      end
      r_res = quot_o;
      r_dz  = dz_o;
      r_it  = iters_o;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_err++;
         n_chk++;
         $display("FAIL R11 watchdog: actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      // R1 reset state
      repeat (3) @(negedge clk);
      check(busy_o == 0 && done_o == 0 && dz_o == 0, "R1 flags in reset",
            {29'd0, busy_o, done_o, dz_o}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check(quot_o == 32'd0, "R1 result after reset", quot_o, 32'd0);
      check(iters_o == 5'd0 && busy_o == 0, "R1 iters and busy after reset",
            {26'd0, busy_o, iters_o}, 32'd0);

      // Table of vectors: R2 R3 R4 R5 R6 R7 R8 R9 R10
      for (int k = 0; k < NV; k++) begin
         run_op(VT[k].a, VT[k].b, VT[k].acc);
         check(r_res == VT[k].res, {rname(VT[k].rq), " result"}, r_res, VT[k].res);
         check(r_dz == VT[k].dz, {rname(VT[k].rq), " dz flag"},
               {31'd0, r_dz}, {31'd0, VT[k].dz});
         check(r_it == VT[k].cyc, "R5 iteration count", {27'd0, r_it}, {27'd0, VT[k].cyc});
         check(r_lat == int'(VT[k].cyc) + 1, "R5 latency (R10 for specials)",
               r_lat, int'(VT[k].cyc) + 1);
         // R11 done lasts one cycle
         @(negedge clk);
         check(done_o == 1'b0, "R11 done pulse width", {31'd0, done_o}, 32'd0);
      end

      // R12 outputs hold between completions
      run_op(32'h3F800000, 32'h40400000, 5'd24);
      dividend_i = 32'h40C00000;
      divisor_i  = 32'h40000000;
      repeat (6) @(negedge clk);
      check(quot_o == 32'h3EAAAAAA, "R12 result held", quot_o, 32'h3EAAAAAA);
      check(iters_o == 5'd24, "R12 iters held", {27'd0, iters_o}, 32'd24);

      // R11 start while busy is ignored
      @(negedge clk);
      dividend_i = 32'h3F800000;
      divisor_i  = 32'h40400000;
      acc_i      = 5'd24;
      start_i    = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      check(busy_o == 1'b1, "R11 busy after start", {31'd0, busy_o}, 32'd1);
      repeat (3) @(negedge clk);
      dividend_i = 32'h40C00000;
      divisor_i  = 32'h40000000;
      acc_i      = 5'd1;
      start_i    = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      begin
         int w = 0;
         while (!done_o && w < 100) begin
            @(negedge clk);
            w++;
         end
      end
      check(quot_o == 32'h3EAAAAAA, "R11 busy start ignored (result)", quot_o, 32'h3EAAAAAA);
      begin
         int extra = 0;
         for (int c = 0; c < 30; c++) begin
            @(negedge clk);
            if (done_o) extra++;
         end
         check(extra == 0, "R11 no second done", extra, 0);
      end

      // R1 reset in the middle of an operation
      @(negedge clk);
      dividend_i = 32'h3F800000;
      divisor_i  = 32'h40400000;
      acc_i      = 5'd24;
      start_i    = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check(busy_o == 0 && quot_o == 32'd0 && iters_o == 5'd0,
            "R1 mid-operation reset", quot_o, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R4 after reset: a fresh short operation still works
      run_op(32'h3F800000, 32'h40400000, 5'd2);
      check(r_res == 32'h3E800000, "R4 two-bit result", r_res, 32'h3E800000);
      check(r_lat == 3, "R5 two-bit latency", r_lat, 3);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule